// File: doc/BRIEF.md
# Configurable Dual-Lane Processing Element

This block is one processing element of a stencil-style image-processing array. It contains two 16-bit arithmetic lanes and a multiply-accumulate unit. A mode input, sampled with every valid input, sets how the lanes work. In split mode they run as two separate 16-bit units. In wide mode they form one 32-bit unit. In chained mode they form a two-step 16-bit datapath in which one lane's result feeds the other lane in the same cycle.

Beside the lanes, a signed 16x16 multiplier adds its product into a 32-bit accumulator. The multiply, the add and the accumulator write all happen in one clock cycle. Every result is registered. A result appears one cycle after its input-valid strobe. Consecutive valid inputs may each use a different mode, and no idle cycle is needed between them.

Top module: `dual_alu_pe`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `res_lo`, `res_hi` and `acc` are all zero.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. In a cycle with `in_valid` low, `res_lo`, `res_hi` and `acc` keep their values.
- R3: With `mode` = 0 (split), `res_lo` = `a1` op1 `b1` and `res_hi` = `a2` op2 `b2`, both computed from the same valid input.
- R4: Opcode encodings are 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 logical left shift, 6 logical right shift, 7 signed minimum and 8 signed maximum. In a 16-bit lane the shift amount is `b[3:0]`. Codes 9 to 15 produce zero.
- R5: With `mode` = 1 (wide), {`res_hi`,`res_lo`} = {`a2`,`a1`} op1 {`b2`,`b1`} as one 32-bit operation. Add and subtract carry or borrow across bit 15, and minimum and maximum compare signed 32-bit values.
- R6: In wide mode, shifts act on the whole 32-bit word, and the amount is `b1[4:0]`.
- R7: With `mode` = 2 (chained), `res_lo` = `a1` op1 (`b1` op2 `c`) and `res_hi` = 0.
- R8: With `mode` = 3 (reserved), both `res_lo` and `res_hi` become zero.
- R9: On each valid input with `acc_clr` low, `acc` becomes `acc` + signed(`mac_x`) × signed(`mac_y`), wrapping modulo 2^32.
- R10: On a valid input with `acc_clr` high, `acc` is loaded with the signed product of `mac_x` and `mac_y`. The old value is dropped.
- R11: A mode change applies to the very next valid input. Back-to-back valid inputs in different modes each give their own correct result in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| mode | input | 2 | 0 split, 1 wide, 2 chained, 3 reserved |
| op1 | input | 4 | Opcode of the first lane (the wide opcode in wide mode) |
| op2 | input | 4 | Opcode of the second lane (the inner opcode in chained mode) |
| a1 | input | 16 | First lane operand A; low half of A in wide mode |
| b1 | input | 16 | First lane operand B; low half of B in wide mode |
| a2 | input | 16 | Second lane operand A; high half of A in wide mode |
| b2 | input | 16 | Second lane operand B; high half of B in wide mode |
| c | input | 16 | Third operand, used only in chained mode |
| mac_x | input | 16 | Signed multiplicand |
| mac_y | input | 16 | Signed multiplier |
| acc_clr | input | 1 | Load the accumulator with the product instead of adding |
| out_valid | output | 1 | Results were updated in the previous cycle |
| res_lo | output | 16 | First-lane result or low half of the wide result |
| res_hi | output | 16 | Second-lane result or high half of the wide result |
| acc | output | 32 | Accumulator value |

## Verification
The block keeps little state: the result registers, the valid flag and the accumulator. A fault in the lane muxing or in the carry link shows up in `res_lo`/`res_hi` one cycle after the affected valid input. Wide carries are only visible when an operand pattern crosses bit 15, and chained faults only when the inner result differs from `b1`. A corrupted accumulator stays wrong in every later sum until a clear loads a fresh product, so a long sequence of accumulations and a wrap past 2^32 bring it out. Holding `in_valid` low while the operands change shows whether any register updates when it should not.

// File: rtl/pe_pkg.sv
package pe_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_SHL = 4'd5,
        OP_SHR = 4'd6,
        OP_MIN = 4'd7,
        OP_MAX = 4'd8
    } alu_op_e;

    typedef enum logic [1:0] {
        MODE_SPLIT = 2'd0,
        MODE_WIDE  = 2'd1,
        MODE_CHAIN = 2'd2,
        MODE_RSVD  = 2'd3
    } pe_mode_e;

endpackage

// File: rtl/pe_lane.sv
// One narrow arithmetic lane with an optional external carry-in.
module pe_lane
    import pe_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           link,
    input  logic           cin,
    output logic [W-1:0]   y,
    output logic           cout
);
    localparam int unsigned SH_W = $clog2(W);

    logic         carry_sel;
    logic [W-1:0] addend;
    logic [W:0]   sum;

    always_comb begin
        // a linked lane takes its carry from the lower lane
        carry_sel = link ? cin : (op == OP_SUB);
        addend    = (op == OP_SUB) ? ~b : b;
        sum       = {1'b0, a} + {1'b0, addend} + {{W{1'b0}}, carry_sel};
        cout      = sum[W];
        case (op)
            OP_ADD, OP_SUB: y = sum[W-1:0];
            OP_AND:         y = a & b;
            OP_OR:          y = a | b;
            OP_XOR:         y = a ^ b;
            OP_SHL:         y = a << b[SH_W-1:0];
            OP_SHR:         y = a >> b[SH_W-1:0];
            OP_MIN:         y = ($signed(a) < $signed(b)) ? a : b;
            OP_MAX:         y = ($signed(a) < $signed(b)) ? b : a;
            default:        y = '0;
        endcase
    end
endmodule

// File: rtl/pe_mac.sv
// Single-cycle signed multiply with accumulate next-value logic.
module pe_mac #(
    parameter int unsigned MW = 16,
    parameter int unsigned AW = 32
) (
    input  logic [MW-1:0] x,
    input  logic [MW-1:0] y,
    input  logic [AW-1:0] acc_cur,
    input  logic          clr,
    output logic [AW-1:0] acc_next
);
    logic signed [2*MW-1:0] prod;
    logic        [AW-1:0]   prod_ext;

    always_comb begin
        prod     = $signed(x) * $signed(y);
        prod_ext = AW'(prod);
        acc_next = clr ? prod_ext : acc_cur + prod_ext;
    end
endmodule

// File: rtl/dual_alu_pe.sv
module dual_alu_pe
    import pe_pkg::*;
#(
    parameter int unsigned LANE_W = 16,
    parameter int unsigned ACC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        mode,
    input  logic [3:0]        op1,
    input  logic [3:0]        op2,
    input  logic [LANE_W-1:0] a1,
    input  logic [LANE_W-1:0] b1,
    input  logic [LANE_W-1:0] a2,
    input  logic [LANE_W-1:0] b2,
    input  logic [LANE_W-1:0] c,
    input  logic [LANE_W-1:0] mac_x,
    input  logic [LANE_W-1:0] mac_y,
    input  logic              acc_clr,
    output logic              out_valid,
    output logic [LANE_W-1:0] res_lo,
    output logic [LANE_W-1:0] res_hi,
    output logic [ACC_W-1:0]  acc
);
    localparam int unsigned WIDE_W  = 2 * LANE_W;
    localparam int unsigned WSH_W   = $clog2(WIDE_W);

    typedef struct packed {
        logic              vld;
        logic [LANE_W-1:0] lo;
        logic [LANE_W-1:0] hi;
        logic [ACC_W-1:0]  acc;
    } pe_state_t;

    pe_state_t st_d, st_q;

    pe_mode_e mode_w;
    alu_op_e  op1_w, op2_w;
    assign mode_w = pe_mode_e'(mode);
    assign op1_w  = alu_op_e'(op1);
    assign op2_w  = alu_op_e'(op2);

    // Feeder lane: second lane in split mode, low half in wide mode,
    // inner operation in chained mode. It only ever feeds forward.
    alu_op_e           fb_op;
    logic [LANE_W-1:0] fb_a, fb_b, fb_y;
    logic              fb_cout;

    // Front lane: first lane in split mode, high half in wide mode,
    // outer operation in chained mode.
    alu_op_e           fa_op;
    logic [LANE_W-1:0] fa_a, fa_b, fa_y;
    logic              fa_link, fa_cout;

    always_comb begin
        fb_op = op2_w;
        fb_a  = a2;
        fb_b  = b2;
        case (mode_w)
            MODE_WIDE: begin
                fb_op = op1_w;
                fb_a  = a1;
                fb_b  = b1;
            end
            MODE_CHAIN: begin
                fb_a  = b1;
                fb_b  = c;
            end
            default: ;
        endcase
    end

    always_comb begin
        fa_op   = op1_w;
        fa_a    = a1;
        fa_b    = b1;
        fa_link = 1'b0;
        case (mode_w)
            MODE_WIDE: begin
                fa_a    = a2;
                fa_b    = b2;
                fa_link = 1'b1;
            end
            MODE_CHAIN: fa_b = fb_y;
            default: ;
        endcase
    end

    pe_lane #(.W(LANE_W)) u_feed (
        .op(fb_op), .a(fb_a), .b(fb_b), .link(1'b0), .cin(1'b0),
        .y(fb_y), .cout(fb_cout)
    );

    pe_lane #(.W(LANE_W)) u_front (
        .op(fa_op), .a(fa_a), .b(fa_b), .link(fa_link), .cin(fb_cout),
        .y(fa_y), .cout(fa_cout)
    );

    // Operations that do not split into two lanes take the whole word.
    logic [WIDE_W-1:0] wa, wb, wide_res;
    always_comb begin
        wa = {a2, a1};
        wb = {b2, b1};
        case (op1_w)
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: wide_res = {fa_y, fb_y};
            OP_SHL:  wide_res = wa << wb[WSH_W-1:0];
            OP_SHR:  wide_res = wa >> wb[WSH_W-1:0];
            OP_MIN:  wide_res = ($signed(wa) < $signed(wb)) ? wa : wb;
            OP_MAX:  wide_res = ($signed(wa) < $signed(wb)) ? wb : wa;
            default: wide_res = '0;
        endcase
    end

    logic [ACC_W-1:0] acc_next;
    pe_mac #(.MW(LANE_W), .AW(ACC_W)) u_mac (
        .x(mac_x), .y(mac_y), .acc_cur(st_q.acc), .clr(acc_clr),
        .acc_next(acc_next)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            case (mode_w)
                MODE_SPLIT: begin
                    st_d.lo = fa_y;
                    st_d.hi = fb_y;
                end
                MODE_WIDE:  {st_d.hi, st_d.lo} = wide_res;
                MODE_CHAIN: begin
                    st_d.lo = fa_y;
                    st_d.hi = '0;
                end
                default: begin
                    st_d.lo = '0;
                    st_d.hi = '0;
                end
            endcase
            st_d.acc = acc_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign res_lo    = st_q.lo;
    assign res_hi    = st_q.hi;
    assign acc       = st_q.acc;

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(res_lo) && $stable(res_hi) && $stable(acc)));

    // R5
    wide_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd1 && op1 == 4'd0) |->
        ({fa_cout, fa_y, fb_y} == ({1'b0, a2, a1} + {1'b0, b2, b1})));

    // R7
    chain_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd2) |=> (res_hi == '0));

    // R8
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd3) |=> (res_lo == '0 && res_hi == '0));

    // R10
    logic signed [WIDE_W-1:0] chk_prod;
    assign chk_prod = $signed(mac_x) * $signed(mac_y);
    acc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && acc_clr) |=> (acc == ACC_W'($past(chk_prod))));

endmodule

// File: tb/dual_alu_pe_tb_top.sv
module dual_alu_pe_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = '0;
    logic [3:0]  op1 = '0, op2 = '0;
    logic [15:0] a1 = '0, b1 = '0, a2 = '0, b2 = '0, c = '0;
    logic [15:0] mac_x = '0, mac_y = '0;
    logic        acc_clr = 1'b0;
    logic        out_valid;
    logic [15:0] res_lo, res_hi;
    logic [31:0] acc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] exp_acc = '0;

    always #10 clk = ~clk;

    dual_alu_pe dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .op1(op1), .op2(op2), .a1(a1), .b1(b1), .a2(a2), .b2(b2), .c(c),
        .mac_x(mac_x), .mac_y(mac_y), .acc_clr(acc_clr),
        .out_valid(out_valid), .res_lo(res_lo), .res_hi(res_hi), .acc(acc)
    );

    function automatic logic [15:0] m16(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
        case (op)
            4'd0: return a + b;
            4'd1: return a - b;
            4'd2: return a & b;
            4'd3: return a | b;
            4'd4: return a ^ b;
            4'd5: return a << b[3:0];
            4'd6: return a >> b[3:0];
            4'd7: return ($signed(a) < $signed(b)) ? a : b;
            4'd8: return ($signed(a) > $signed(b)) ? a : b;
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic [31:0] m32(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            4'd0: return a + b;
            4'd1: return a - b;
            4'd2: return a & b;
            4'd3: return a | b;
            4'd4: return a ^ b;
            4'd5: return a << b[4:0];
            4'd6: return a >> b[4:0];
            4'd7: return ($signed(a) < $signed(b)) ? a : b;
            4'd8: return ($signed(a) > $signed(b)) ? a : b;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] mprod(input logic [15:0] x, input logic [15:0] y);
        logic signed [31:0] p;
        p = $signed(x) * $signed(y);
        return p;
    endfunction

    function automatic logic [31:0] model(input logic [1:0] md, input logic [3:0] o1, input logic [3:0] o2,
                                          input logic [15:0] xa1, input logic [15:0] xb1,
                                          input logic [15:0] xa2, input logic [15:0] xb2,
                                          input logic [15:0] xc);
        case (md)
            2'd0: return {m16(o2, xa2, xb2), m16(o1, xa1, xb1)};
            2'd1: return m32(o1, {xa2, xa1}, {xb2, xb1});
            2'd2: return {16'h0, m16(o1, xa1, m16(o2, xb1, xc))};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive one valid input, then check the registered results after the edge
    task automatic apply(input string req, input logic [1:0] md, input logic [3:0] o1, input logic [3:0] o2,
                         input logic [15:0] xa1, input logic [15:0] xb1,
                         input logic [15:0] xa2, input logic [15:0] xb2, input logic [15:0] xc,
                         input logic [15:0] mx, input logic [15:0] my, input logic clr);
        logic [31:0] exp_res;
        @(negedge clk);
        mode = md; op1 = o1; op2 = o2;
        a1 = xa1; b1 = xb1; a2 = xa2; b2 = xb2; c = xc;
        mac_x = mx; mac_y = my; acc_clr = clr; in_valid = 1'b1;
        exp_res = model(md, o1, o2, xa1, xb1, xa2, xb2, xc);
        exp_acc = clr ? mprod(mx, my) : exp_acc + mprod(mx, my);
        @(posedge clk);
        #1;
        check(req, "result", {res_hi, res_lo}, exp_res);
        check(clr ? "R10" : "R9", "acc", acc, exp_acc);
        check("R2", "out_valid", {31'h0, out_valid}, 32'h1);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        acc_clr = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R1", "out_valid", {31'h0, out_valid}, 32'h0);
        check("R1", "results", {res_hi, res_lo}, 32'h0);
        check("R1", "acc", acc, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_split();
        apply("R3", 2'd0, 4'd0, 4'd1, 16'h1234, 16'h0101, 16'h0005, 16'h0007, 16'h0, 16'h0, 16'h0, 1'b0);
        apply("R3", 2'd0, 4'd4, 4'd8, 16'hF0F0, 16'h0FF0, 16'h8000, 16'h7FFF, 16'h0, 16'h0, 16'h0, 1'b0);
        apply("R3", 2'd0, 4'd0, 4'd0, 16'hFFFF, 16'h0001, 16'hFFFF, 16'h0001, 16'h0, 16'h0, 16'h0, 1'b0);
        idle();
    endtask

    task automatic t_opcodes();
        for (int op = 0; op < 16; op++) begin
            apply("R4", 2'd0, 4'(op), 4'(op), 16'h8001, 16'h0003, 16'h1234, 16'hFFF0, 16'h0,
                  16'h0, 16'h0, 1'b0);
        end
        // shift amount uses only the low four bits
        apply("R4", 2'd0, 4'd5, 4'd6, 16'h0003, 16'h0012, 16'h8000, 16'h0021, 16'h0, 16'h0, 16'h0, 1'b0);
        idle();
    endtask

    task automatic t_wide();
        apply("R5", 2'd1, 4'd0, 4'd3, 16'hFFFF, 16'h0001, 16'h0000, 16'h0000, 16'h0, 16'h0, 16'h0, 1'b0);
        apply("R5", 2'd1, 4'd1, 4'd3, 16'h0000, 16'h0001, 16'h0001, 16'h0000, 16'h0, 16'h0, 16'h0, 1'b0);
        apply("R5", 2'd1, 4'd7, 4'd0, 16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h0, 16'h0, 16'h0, 1'b0);
        apply("R5", 2'd1, 4'd8, 4'd0, 16'h0001, 16'h0000, 16'hFFFF, 16'h0000, 16'h0, 16'h0, 16'h0, 1'b0);
        apply("R5", 2'd1, 4'd4, 4'd0, 16'hAAAA, 16'hFFFF, 16'h5555, 16'h0F0F, 16'h0, 16'h0, 16'h0, 1'b0);
        apply("R5", 2'd1, 4'd12, 4'd0, 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 16'h0, 16'h0, 16'h0, 1'b0);
        idle();
    endtask

    task automatic t_shift32();
        apply("R6", 2'd1, 4'd5, 4'd0, 16'h8001, 16'h0001, 16'h0000, 16'h0000, 16'h0, 16'h0, 16'h0, 1'b0);
        apply("R6", 2'd1, 4'd6, 4'd0, 16'h0000, 16'h001F, 16'h8000, 16'h0000, 16'h0, 16'h0, 16'h0, 1'b0);
        apply("R6", 2'd1, 4'd5, 4'd0, 16'h00FF, 16'h0011, 16'h0000, 16'h0000, 16'h0, 16'h0, 16'h0, 1'b0);
        idle();
    endtask

    task automatic t_chain();
        apply("R7", 2'd2, 4'd1, 4'd0, 16'd100, 16'd30, 16'h7777, 16'h1111, 16'd20, 16'h0, 16'h0, 1'b0);
        apply("R7", 2'd2, 4'd4, 4'd5, 16'h00FF, 16'h0003, 16'h0, 16'h0, 16'h0004, 16'h0, 16'h0, 1'b0);
        apply("R7", 2'd2, 4'd8, 4'd7, 16'hFFFE, 16'h8000, 16'h0, 16'h0, 16'h0005, 16'h0, 16'h0, 1'b0);
        idle();
    endtask

    task automatic t_rsvd();
        apply("R3", 2'd0, 4'd3, 4'd3, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h0, 16'h0, 16'h0, 1'b0);
        apply("R8", 2'd3, 4'd0, 4'd0, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555, 16'h0, 16'h0, 1'b0);
        idle();
    endtask

    task automatic t_hold();
        logic [31:0] r_save, a_save;
        apply("R3", 2'd0, 4'd0, 4'd0, 16'h0010, 16'h0020, 16'h0030, 16'h0040, 16'h0, 16'h0003, 16'h0004, 1'b0);
        idle();
        r_save = {res_hi, res_lo};
        a_save = acc;
        a1 = 16'hDEAD; b2 = 16'hBEEF; mac_x = 16'h7FFF; mac_y = 16'h7FFF; acc_clr = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R2", "idle out_valid", {31'h0, out_valid}, 32'h0);
        check("R2", "idle results", {res_hi, res_lo}, r_save);
        check("R2", "idle acc", acc, a_save);
        acc_clr = 1'b0;
    endtask

    task automatic t_mac();
        apply("R10", 2'd0, 4'd0, 4'd0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h8000, 16'h8000, 1'b1);
        for (int i = 0; i < 3; i++)
            apply("R9", 2'd0, 4'd0, 4'd0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h8000, 16'h8000, 1'b0);
        check("R9", "wrap to zero", acc, 32'h0);
        apply("R9", 2'd0, 4'd0, 4'd0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'hFFFD, 16'h0007, 1'b0);
        apply("R9", 2'd0, 4'd0, 4'd0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0100, 16'h0100, 1'b0);
        apply("R10", 2'd0, 4'd0, 4'd0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'hFFFF, 16'h0002, 1'b1);
        idle();
    endtask

    task automatic t_switch();
        apply("R11", 2'd0, 4'd0, 4'd1, 16'h00FF, 16'h0001, 16'h0100, 16'h0001, 16'h0002, 16'h0002, 16'h0003, 1'b0);
        apply("R11", 2'd1, 4'd0, 4'd1, 16'hFFFF, 16'h0001, 16'h0100, 16'h0001, 16'h0002, 16'h0002, 16'h0003, 1'b0);
        apply("R11", 2'd2, 4'd0, 4'd1, 16'h00FF, 16'h0001, 16'h0100, 16'h0001, 16'h0002, 16'h0002, 16'h0003, 1'b0);
        apply("R11", 2'd0, 4'd2, 4'd3, 16'h00FF, 16'h0F0F, 16'h0100, 16'h0001, 16'h0002, 16'h0002, 16'h0003, 1'b0);
        idle();
    endtask

    initial begin
        t_reset();
        t_split();
        t_opcodes();
        t_wide();
        t_shift32();
        t_chain();
        t_rsvd();
        t_hold();
        t_mac();
        t_switch();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule